// File: doc/BRIEF.md
# Receive Word-to-User Width Adapter

This block sits between a receiver's internal parallel datapath and the logic that consumes received data. The internal side delivers one word per internal clock cycle, either two 8-bit bytes (16-bit mode) or two raw 10-bit symbols (20-bit mode, used when line decoding is bypassed). The user side takes one, two or four symbol lanes per user clock cycle. The user clock is edge-aligned to the internal clock and runs at twice, the same as, or half the internal rate, so the lane count always matches the internal throughput.

Each output lane carries eight data bits on the main data bus. In 20-bit mode the remaining two bits of each 10-bit symbol leave on two per-lane flag outputs, so that a 10-bit or 20-bit user view is assembled from the data bus plus flags. In 16-bit mode those flags stay low. An active-low asynchronous reset clears every datapath register and the byte-phase counter.

Top module: `rx_width_adapter`

## Requirements
- R1: With `intWide` low, each internal word holds two bytes: symbol 0 is `intData[7:0]`, symbol 1 is `intData[15:8]`; `intData[19:16]` has no effect and both flag outputs stay zero.
- R2: With `intWide` high, symbol 0 is `intData[9:0]` and symbol 1 is `intData[19:10]`; on output lane L, symbol bits [7:0] appear on `usrData[8L+7:8L]`, bit 8 on `usrCtrlFlag[L]` and bit 9 on `usrDispFlag[L]`.
- R3: With `widthSel` = 1 (user clock equal to internal clock), each user edge presents symbol 0 on lane 0 and symbol 1 on lane 1 of the word captured at the previous shared edge; lanes 2 and 3 are zero.
- R4: With `widthSel` = 0 (user clock twice the internal clock), lane 0 shows symbol 0 of a word on an edge shared with the internal clock and symbol 1 of the same word on the following edge; lanes 1 to 3 are zero.
- R5: With `widthSel` = 2 (user clock half the internal clock), the earlier of two consecutive words occupies lanes 0 and 1 and the later one lanes 2 and 3.
- R6: After reset release, whose first user edge must coincide with an internal edge, the byte phase starts at zero; the first user cycle (first two in one-lane mode) outputs zero, after which the word stream follows in order with no loss or repetition. Outside one-lane mode the phase stays at zero.
- R7: Driving `rstN` low forces all outputs to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intClk | input | 1 | Internal datapath clock |
| usrClk | input | 1 | User clock, rising edges aligned to `intClk` |
| rstN | input | 1 | Asynchronous reset, active low |
| intWide | input | 1 | Internal width mode: 0 = 16-bit, 1 = 20-bit |
| widthSel | input | 2 | Lanes per user cycle: 0 = one, 1 = two, 2 = four |
| intData | input | 20 | Internal receive word, sampled on `intClk` |
| usrData | output | 32 | Eight data bits per lane, lane 0 in the low byte |
| usrCtrlFlag | output | 4 | Bit 8 of each lane's symbol (20-bit mode) |
| usrDispFlag | output | 4 | Bit 9 of each lane's symbol (20-bit mode) |

## Verification
The bench streams distinct numbered words through all three lane settings in both internal widths and compares every user-cycle output, including the zero cycles right after reset release. A design that swapped the byte order in one-lane mode, or re-read the live internal register on the mid-cycle edge, would present the next word's upper symbol instead of the current one; a design that paired words the wrong way in four-lane mode would put the later word in the low half. Routing the symbol's top two bits to the wrong flag, or letting `intData[19:16]` leak in 16-bit mode, shows up as flag miscompares, and a synchronous reset would leave stale data on the outputs when `rstN` drops between edges.

// File: rtl/rx_width_pkg.sv
package rx_width_pkg;

  localparam int SYM_W      = 10;
  localparam int BYTE_W     = 8;
  localparam int NUM_LANES  = 4;
  localparam int WORD_SYMS  = 2;
  localparam int WORD_W     = WORD_SYMS * SYM_W;
  localparam int FLAG_BITS  = SYM_W - BYTE_W;

  typedef enum logic [1:0] {
    WSEL_ONE  = 2'd0,
    WSEL_TWO  = 2'd1,
    WSEL_FOUR = 2'd2
  } wsel_e;

  // strobes from the user-side control to the datapath
  typedef struct packed {
    logic oneLane;
    logic twoLane;
    logic fourLane;
    logic phaseHi;
  } lane_ctrl_t;

endpackage

// File: rtl/rx_width_norm.sv
module rx_width_norm
  import rx_width_pkg::*;
(
  input  logic                               intWide,
  input  logic [WORD_W-1:0]                  rawWord,
  output logic [WORD_SYMS-1:0][SYM_W-1:0]    syms
);

  // one slicer per symbol: raw 10-bit symbol or zero-extended byte
  for (genvar i = 0; i < WORD_SYMS; i++) begin : gSym
    always_comb begin
      if (intWide) begin
        syms[i] = rawWord[SYM_W*i +: SYM_W];
      end else begin
        syms[i] = {{FLAG_BITS{1'b0}}, rawWord[BYTE_W*i +: BYTE_W]};
      end
    end
  end

endmodule

// File: rtl/rx_width_ctrl.sv
module rx_width_ctrl
  import rx_width_pkg::*;
(
  input  logic       usrClk,
  input  logic       rstN,
  input  logic [1:0] widthSel,
  output lane_ctrl_t ctrl
);

  logic phaseReg;
  logic isOne;
  logic isFour;

  assign isOne  = (widthSel == WSEL_ONE);
  assign isFour = widthSel[1];

  // byte phase: toggles every user cycle in one-lane mode, parked otherwise
  always_ff @(posedge usrClk or negedge rstN) begin
    if (!rstN) begin
      phaseReg <= 1'b0;
    end else if (isOne) begin
      phaseReg <= ~phaseReg;
    end else begin
      phaseReg <= 1'b0;
    end
  end

  always_comb begin
    ctrl.oneLane  = isOne;
    ctrl.fourLane = isFour;
    ctrl.twoLane  = !isOne && !isFour;
    ctrl.phaseHi  = phaseReg;
  end

  AST_PHASE_ALTERNATES: assert property (@(posedge usrClk) disable iff (!rstN)
    isOne |=> (phaseReg != $past(phaseReg))); // R4

  AST_PHASE_PARKED: assert property (@(posedge usrClk) disable iff (!rstN)
    !isOne |=> !phaseReg); // R6

endmodule

// File: rtl/rx_width_dp.sv
module rx_width_dp
  import rx_width_pkg::*;
(
  input  logic                     intClk,
  input  logic                     usrClk,
  input  logic                     rstN,
  input  logic                     intWide,
  input  logic [WORD_W-1:0]        intData,
  input  lane_ctrl_t               ctrl,
  output logic [NUM_LANES*BYTE_W-1:0] usrData,
  output logic [NUM_LANES-1:0]     usrCtrlFlag,
  output logic [NUM_LANES-1:0]     usrDispFlag
);

  localparam int OUT_W = NUM_LANES * BYTE_W;

  logic [WORD_SYMS-1:0][SYM_W-1:0] normSyms;
  logic [WORD_SYMS-1:0][SYM_W-1:0] curSyms;
  logic [WORD_SYMS-1:0][SYM_W-1:0] prevSyms;
  logic [SYM_W-1:0]                holdSym;
  logic [NUM_LANES-1:0][SYM_W-1:0] laneReg;
  logic [NUM_LANES-1:0][SYM_W-1:0] laneNext;

  rx_width_norm uNorm (
    .intWide (intWide),
    .rawWord (intData),
    .syms    (normSyms)
  );

  // internal-domain capture: newest word and the one before it
  always_ff @(posedge intClk or negedge rstN) begin
    if (!rstN) begin
      curSyms  <= '0;
      prevSyms <= '0;
    end else begin
      curSyms  <= normSyms;
      prevSyms <= curSyms;
    end
  end

  // lane assembly for the next user cycle
  always_comb begin
    laneNext = '0;
    if (ctrl.fourLane) begin
      laneNext[0] = prevSyms[0];
      laneNext[1] = prevSyms[1];
      laneNext[2] = curSyms[0];
      laneNext[3] = curSyms[1];
    end else if (ctrl.twoLane) begin
      laneNext[0] = curSyms[0];
      laneNext[1] = curSyms[1];
    end else if (ctrl.oneLane) begin
      laneNext[0] = ctrl.phaseHi ? holdSym : curSyms[0];
    end
  end

  // user-domain registers; the upper symbol is parked on the shared edge
  always_ff @(posedge usrClk or negedge rstN) begin
    if (!rstN) begin
      laneReg <= '0;
      holdSym <= '0;
    end else begin
      laneReg <= laneNext;
      if (ctrl.oneLane && !ctrl.phaseHi) begin
        holdSym <= curSyms[1];
      end
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    assign usrData[BYTE_W*l +: BYTE_W] = laneReg[l][BYTE_W-1:0];
    assign usrCtrlFlag[l]              = laneReg[l][BYTE_W];
    assign usrDispFlag[l]              = laneReg[l][BYTE_W+1];
  end

  AST_NARROW_NO_FLAGS: assert property (@(posedge intClk) disable iff (!rstN)
    !intWide |=> (curSyms[0][SYM_W-1:BYTE_W] == '0 && curSyms[1][SYM_W-1:BYTE_W] == '0)); // R1

  AST_BYTE_LANE_ONLY: assert property (@(posedge usrClk) disable iff (!rstN)
    ctrl.oneLane |=> (usrData[OUT_W-1:BYTE_W] == '0 && usrCtrlFlag[NUM_LANES-1:1] == '0
                      && usrDispFlag[NUM_LANES-1:1] == '0)); // R4

  AST_UPPER_LANES_IDLE: assert property (@(posedge usrClk) disable iff (!rstN)
    ctrl.twoLane |=> (usrData[OUT_W-1:2*BYTE_W] == '0 && usrCtrlFlag[NUM_LANES-1:2] == '0
                      && usrDispFlag[NUM_LANES-1:2] == '0)); // R3

endmodule

// File: rtl/rx_width_adapter.sv
module rx_width_adapter
  import rx_width_pkg::*;
(
  input  logic                         intClk,
  input  logic                         usrClk,
  input  logic                         rstN,
  input  logic                         intWide,
  input  logic [1:0]                   widthSel,
  input  logic [WORD_W-1:0]            intData,
  output logic [NUM_LANES*BYTE_W-1:0]  usrData,
  output logic [NUM_LANES-1:0]         usrCtrlFlag,
  output logic [NUM_LANES-1:0]         usrDispFlag
);

  lane_ctrl_t laneCtrl;

  rx_width_ctrl uCtrl (
    .usrClk   (usrClk),
    .rstN     (rstN),
    .widthSel (widthSel),
    .ctrl     (laneCtrl)
  );

  rx_width_dp uDp (
    .intClk      (intClk),
    .usrClk      (usrClk),
    .rstN        (rstN),
    .intWide     (intWide),
    .intData     (intData),
    .ctrl        (laneCtrl),
    .usrData     (usrData),
    .usrCtrlFlag (usrCtrlFlag),
    .usrDispFlag (usrDispFlag)
  );

endmodule

// File: tb/rx_width_adapter_test.sv
module rx_width_adapter_test;

  // 10 ns tick: the one-lane user clock is 50 MHz, the internal clock 25 MHz
  logic        intClk = 1'b1;
  logic        usrClk = 1'b1;
  logic        rstN = 1'b0;
  logic        intWide = 1'b0;
  logic [1:0]  widthSel = 2'd0;
  logic [19:0] intData = '0;
  logic [31:0] usrData;
  logic [3:0]  usrCtrlFlag;
  logic [3:0]  usrDispFlag;

  int tickCnt = 0;
  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [39:0] expQ[$];

  rx_width_adapter uut (
    .intClk      (intClk),
    .usrClk      (usrClk),
    .rstN        (rstN),
    .intWide     (intWide),
    .widthSel    (widthSel),
    .intData     (intData),
    .usrData     (usrData),
    .usrCtrlFlag (usrCtrlFlag),
    .usrDispFlag (usrDispFlag)
  );

  initial begin
    forever begin
      #10;
      tickCnt++;
      intClk = (tickCnt % 4) < 2;
      case (widthSel)
        2'd0:    usrClk = (tickCnt % 2) < 1;
        2'd1:    usrClk = (tickCnt % 4) < 2;
        default: usrClk = (tickCnt % 8) < 4;
      endcase
    end
  end

  function automatic logic [19:0] wordOf(int n);
    return 20'h3C5A7 ^ (20'(n) * 20'h1F3B5);
  endfunction

  function automatic logic [9:0] symOf(logic [19:0] w, int i, logic wide);
    if (wide) return w[10*i +: 10];
    return {2'b00, w[8*i +: 8]};
  endfunction

  function automatic logic [39:0] putLane(logic [39:0] item, int l, logic [9:0] s);
    logic [39:0] r = item;
    r[8*l +: 8] = s[7:0];
    r[32 + l]   = s[8];
    r[36 + l]   = s[9];
    return r;
  endfunction

  function automatic logic [39:0] outNow();
    return {usrDispFlag, usrCtrlFlag, usrData};
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runCase(logic [1:0] sel, logic wide, int nWords);
    string tag;
    int startup;
    tag = (sel == 2'd0) ? "R4" : (sel == 2'd1) ? "R3" : "R5";
    tag = {tag, wide ? "/R2" : "/R1"};
    rstN = 1'b0;
    widthSel = sel;
    intWide = wide;
    intData = wordOf(0);
    #37;
    check("R7 outputs in reset", outNow(), '0);

    // scoreboard fill: startup zeros, then the ordered stream
    expQ.delete();
    startup = (sel == 2'd0) ? 2 : 1;
    for (int i = 0; i < startup; i++) expQ.push_back('0);
    if (sel == 2'd1) begin
      for (int n = 0; n < nWords; n++) begin
        logic [39:0] it = '0;
        it = putLane(it, 0, symOf(wordOf(n), 0, wide));
        it = putLane(it, 1, symOf(wordOf(n), 1, wide));
        expQ.push_back(it);
      end
    end else if (sel == 2'd0) begin
      for (int n = 0; n < nWords; n++) begin
        expQ.push_back(putLane('0, 0, symOf(wordOf(n), 0, wide)));
        expQ.push_back(putLane('0, 0, symOf(wordOf(n), 1, wide)));
      end
    end else begin
      for (int n = 0; n < nWords; n += 2) begin
        logic [39:0] it = '0;
        it = putLane(it, 0, symOf(wordOf(n), 0, wide));
        it = putLane(it, 1, symOf(wordOf(n), 1, wide));
        it = putLane(it, 2, symOf(wordOf(n + 1), 0, wide));
        it = putLane(it, 3, symOf(wordOf(n + 1), 1, wide));
        expQ.push_back(it);
      end
    end

    // release just before an edge shared by both clocks
    wait (tickCnt % 8 == 7);
    #5;
    rstN = 1'b1;

    fork
      begin : driver
        for (int n = 1; n < nWords; n++) begin
          @(negedge intClk);
          intData = wordOf(n);
        end
      end
      begin : monitor
        int k = 0;
        while (expQ.size() > 0) begin
          logic [39:0] e;
          @(posedge usrClk);
          #3;
          e = expQ.pop_front();
          if (k < startup) check("R6 startup zero", outNow(), e);
          else check(tag, outNow(), e);
          k++;
        end
      end
    join

    // asynchronous reset between edges
    rstN = 1'b0;
    #1;
    check("R7 async clear", outNow(), '0);
  endtask

  initial begin
    runCase(2'd1, 1'b0, 16);
    runCase(2'd1, 1'b1, 16);
    runCase(2'd0, 1'b0, 16);
    runCase(2'd0, 1'b1, 16);
    runCase(2'd2, 1'b0, 16);
    runCase(2'd2, 1'b1, 16);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule